// File: doc/BRIEF.md
# Clock Multiplier Mode Sequencer

This block holds the setup byte of a network controller core and sequences the switch of that core onto a multiplied clock. A CPU writes bytes over a small register bus. One select line picks either the setup register or the command register. The setup byte carries four things:

- a two-bit clock multiplier code;
- an enhanced-function flag;
- a fast-read timing enable;
- a flag that drops the need for an idle line before the RAM is initialised.

When a write changes the multiplier code to a new legal value, the block halts the core and powers up the PLL. The PLL stays enabled from then on. The core stays halted until software writes the restart byte 0x18 to the command register and the PLL reports lock. If the restart byte comes first, it is remembered until lock arrives. The multiplier code can change only once between hardware resets. A sticky error flag records any time the fastest mode is active while the enhanced-function flag is clear.

Top module: `ckm_sequencer`

## Requirements
- R1: After a synchronous reset the outputs are as follows: `setup_rd`=0x00, `mult_sel`=00, `pll_en`=0, `core_run`=1, `fast_rd_en`=0, `enh_func_en`=0, `line_idle_req`=1 and `cfg_err`=0.
- R2: The setup byte layout is: bit 7 is the read-timing enable, bits 5:4 are the multiplier code, bit 3 is the enhanced-function flag and bit 2 is the sync-disable flag. Bits 6, 1 and 0 always read back as 0 on `setup_rd`.
- R3: The multiplier code means: 00 is the base clock, 01 is double, 11 is quadruple and 10 is reserved. `mult_sel` never shows 10.
- R4: A setup write whose code is legal, differs from the current code and comes while the one-time allowance is unused has these effects from the next cycle: `mult_sel` takes the new code, `core_run`=0 and `pll_en`=1. `pll_en` then stays 1 until reset.
- R5: A setup write with code 10, or with the code already selected, leaves `mult_sel` and `core_run` unchanged. It does not use up the allowance. The other setup fields are still written.
- R6: After one accepted change, later codes are ignored until reset.
- R7: A command write of 0x18 while halted, with `pll_lock`=1, sets `core_run`=1 on the next cycle. Any other command byte has no effect. So does 0x18 while the core is running.
- R8: A 0x18 command that arrives while halted and with `pll_lock`=0 is held. `core_run` rises on the cycle after the first cycle in which `pll_lock` is sampled high.
- R9: `fast_rd_en` is 1 exactly when `bus_tmg_pin`=1 and the read-timing bit is 1.
- R10: `cfg_err` is set one cycle after `mult_sel`=11 is seen together with enhanced-function=0. It stays set until reset.
- R11: `enh_func_en` follows bit 3. `line_idle_req` is the inverse of bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | 0 selects the setup register, 1 selects the command register |
| bus_wdata | input | 8 | Write data |
| bus_tmg_pin | input | 1 | External fast bus timing strap |
| pll_lock | input | 1 | PLL lock indication |
| setup_rd | output | 8 | Setup register readback |
| mult_sel | output | 2 | Active multiplier code |
| pll_en | output | 1 | PLL power enable |
| core_run | output | 1 | Core run enable |
| fast_rd_en | output | 1 | Fast CPU read enable |
| enh_func_en | output | 1 | Enhanced-function enable |
| line_idle_req | output | 1 | Idle line required before RAM initialisation |
| cfg_err | output | 1 | Sticky error: fastest mode active without enhanced functions |

## Verification
The mode switch is driven with several kinds of setup write: a reserved code, a rewrite of the current code, a real change, and a second change after the first. These show that only a real first change halts the core and uses up the allowance. The restart is tried in four ways: with lock already high, with lock still low (so it must be held), with the wrong command byte, and while the core is running. These separate immediate restart from pending restart from no effect. The fast-read strap is toggled with the timing bit both set and clear. The quadruple code is entered once with the enhanced flag clear, and the flag is later set to show that the error bit stays set.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    parameter int DATA_W = 8;

    localparam int BIT_RBT    = 7;
    localparam int BIT_MUL_HI = 5;
    localparam int BIT_MUL_LO = 4;
    localparam int BIT_EF     = 3;
    localparam int BIT_NOSYNC = 2;

    typedef enum logic [1:0] {
        MUL_X1  = 2'b00,
        MUL_X2  = 2'b01,
        MUL_RSV = 2'b10,
        MUL_X4  = 2'b11
    } mult_e;

    typedef struct packed {
        logic  rbt;
        mult_e mult;
        logic  ef;
        logic  nosync;
    } setup_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_ARMED = 2'd2
    } seq_st_e;

    function automatic setup_t unpack_setup(input logic [DATA_W-1:0] b);
        setup_t s;
        s.rbt    = b[BIT_RBT];
        s.mult   = mult_e'(b[BIT_MUL_HI:BIT_MUL_LO]);
        s.ef     = b[BIT_EF];
        s.nosync = b[BIT_NOSYNC];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_setup(input setup_t s);
        logic [DATA_W-1:0] b;
        b = '0;
        b[BIT_RBT]               = s.rbt;
        b[BIT_MUL_HI:BIT_MUL_LO] = s.mult;
        b[BIT_EF]                = s.ef;
        b[BIT_NOSYNC]            = s.nosync;
        return b;
    endfunction

endpackage

// File: rtl/ckm_setup_reg.sv
module ckm_setup_reg
    import ckm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_setup,
    input  setup_t wr_val,
    output setup_t cfg,
    output logic   chg_req
);

    setup_t cfg_q;
    logic   used_q;

    // a real change: legal, different, allowance still unused
    assign chg_req = wr_setup && (wr_val.mult != MUL_RSV) &&
                     (wr_val.mult != cfg_q.mult) && !used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.rbt    <= 1'b0;
            cfg_q.mult   <= MUL_X1;
            cfg_q.ef     <= 1'b0;
            cfg_q.nosync <= 1'b0;
            used_q       <= 1'b0;
        end else if (wr_setup) begin
            cfg_q.rbt    <= wr_val.rbt;
            cfg_q.ef     <= wr_val.ef;
            cfg_q.nosync <= wr_val.nosync;
            if (chg_req) begin
                cfg_q.mult <= wr_val.mult;
                used_q     <= 1'b1;
            end
        end
    end

    assign cfg = cfg_q;

    assert_mult_legal_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mult != MUL_RSV);

    assert_once_only_R6: assert property (@(posedge clk) disable iff (rst)
        used_q |=> $stable(cfg_q.mult));

endmodule

// File: rtl/ckm_seq.sv
module ckm_seq
    import ckm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chg_req,
    input  logic restart_cmd,
    input  logic pll_lock,
    output logic core_run,
    output logic pll_en
);

    seq_st_e st_q;
    logic    pll_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            pll_q <= 1'b0;
        end else begin
            if (chg_req) pll_q <= 1'b1;
            case (st_q)
                ST_RUN:   if (chg_req) st_q <= ST_HALT;
                ST_HALT:  if (restart_cmd) st_q <= pll_lock ? ST_RUN : ST_ARMED;
                ST_ARMED: if (pll_lock) st_q <= ST_RUN;
                default:  st_q <= ST_HALT;
            endcase
        end
    end

    assign core_run = (st_q == ST_RUN);
    assign pll_en   = pll_q;

    assert_halt_on_change_R4: assert property (@(posedge clk) disable iff (rst)
        chg_req |=> (!core_run && pll_en));

    assert_pll_hold_R4: assert property (@(posedge clk) disable iff (rst)
        pll_en |=> pll_en);

    assert_run_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run) |-> $past(pll_lock));

endmodule

// File: rtl/ckm_sequencer.sv
module ckm_sequencer
    import ckm_pkg::*;
#(
    parameter logic [7:0] RESTART_CMD = 8'h18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_sel,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_tmg_pin,
    input  logic        pll_lock,
    output logic [7:0]  setup_rd,
    output logic [1:0]  mult_sel,
    output logic        pll_en,
    output logic        core_run,
    output logic        fast_rd_en,
    output logic        enh_func_en,
    output logic        line_idle_req,
    output logic        cfg_err
);

    setup_t cfg;
    logic   chg_req;
    logic   restart_cmd;
    logic   err_q;

    assign restart_cmd = bus_we && bus_sel && (bus_wdata == RESTART_CMD);

    ckm_setup_reg u_setup (
        .clk      (clk),
        .rst      (rst),
        .wr_setup (bus_we && !bus_sel),
        .wr_val   (unpack_setup(bus_wdata)),
        .cfg      (cfg),
        .chg_req  (chg_req)
    );

    ckm_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .chg_req     (chg_req),
        .restart_cmd (restart_cmd),
        .pll_lock    (pll_lock),
        .core_run    (core_run),
        .pll_en      (pll_en)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  err_q <= 1'b0;
        else if (cfg.mult == MUL_X4 && !cfg.ef)   err_q <= 1'b1;
    end

    assign setup_rd      = pack_setup(cfg);
    assign mult_sel      = cfg.mult;
    assign fast_rd_en    = bus_tmg_pin & cfg.rbt;
    assign enh_func_en   = cfg.ef;
    assign line_idle_req = ~cfg.nosync;
    assign cfg_err       = err_q;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

// File: tb/tb_ckm_sequencer.sv
`timescale 1ns/1ps
module tb_ckm_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_tmg_pin = 1'b0;
    logic       pll_lock = 1'b0;
    logic [7:0] setup_rd;
    logic [1:0] mult_sel;
    logic       pll_en, core_run, fast_rd_en, enh_func_en, line_idle_req, cfg_err;

    int total = 0;
    int bad = 0;
    int started = 0;
    int finished = 0;

    always #2.5 clk = ~clk;

    ckm_sequencer dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_tmg_pin(bus_tmg_pin), .pll_lock(pll_lock),
        .setup_rd(setup_rd), .mult_sel(mult_sel), .pll_en(pll_en),
        .core_run(core_run), .fast_rd_en(fast_rd_en), .enh_func_en(enh_func_en),
        .line_idle_req(line_idle_req), .cfg_err(cfg_err)
    );

    // behavioural reference state
    int m_rbt, m_mult, m_ef, m_ns, m_used, m_run, m_pend, m_pll, m_err;

    always @(posedge clk) begin
        int o_mult, o_ef, o_run, o_pend, o_used;
        started = 1;
        if (rst) begin
            m_rbt = 0; m_mult = 0; m_ef = 0; m_ns = 0; m_used = 0;
            m_run = 1; m_pend = 0; m_pll = 0; m_err = 0;
        end else begin
            o_mult = m_mult; o_ef = m_ef; o_run = m_run; o_pend = m_pend; o_used = m_used;
            if (o_mult == 3 && o_ef == 0) m_err = 1;
            if (o_pend && pll_lock) begin
                m_run = 1; m_pend = 0;
            end
            if (bus_we && !bus_sel) begin
                m_rbt = bus_wdata[7];
                m_ef  = bus_wdata[3];
                m_ns  = bus_wdata[2];
                if (bus_wdata[5:4] != 2 && bus_wdata[5:4] != o_mult && !o_used) begin
                    m_mult = bus_wdata[5:4]; m_used = 1; m_run = 0; m_pll = 1;
                end
            end
            if (bus_we && bus_sel && bus_wdata == 8'h18 && !o_run && !o_pend) begin
                if (pll_lock) m_run = 1;
                else m_pend = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started != 0 && finished == 0) begin
            chk("R2 setup_rd", setup_rd, (m_rbt << 7) | (m_mult << 4) | (m_ef << 3) | (m_ns << 2));
            chk("R6 mult_sel", mult_sel, m_mult);
            chk("R4 pll_en", pll_en, m_pll);
            chk("R8 core_run", core_run, m_run);
            chk("R9 fast_rd_en", fast_rd_en, (bus_tmg_pin && m_rbt) ? 1 : 0);
            chk("R11 enh_func_en", enh_func_en, m_ef);
            chk("R11 line_idle_req", line_idle_req, m_ns ? 0 : 1);
            chk("R10 cfg_err", cfg_err, m_err);
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        #20000;
        if (finished == 0) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset values
        chk("R1 setup_rd", setup_rd, 0);
        chk("R1 mult_sel", mult_sel, 0);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 core_run", core_run, 1);
        chk("R1 line_idle_req", line_idle_req, 1);
        chk("R1 cfg_err", cfg_err, 0);

        // R5/R2: reserved code with all bits set, reserved bits read 0
        wr(1'b0, 8'hEF);
        chk("R2 readback", setup_rd, 8'h8C);
        chk("R5 reserved code no halt", core_run, 1);
        chk("R3 code 10 not selected", mult_sel, 0);
        // R9 strap toggling
        bus_tmg_pin = 1'b1;
        #1 chk("R9 fast read on", fast_rd_en, 1);
        wr(1'b0, 8'h04);
        chk("R9 fast read off with bit clear", fast_rd_en, 0);
        chk("R11 idle not required", line_idle_req, 0);
        bus_tmg_pin = 1'b0;
        // R5 same code rewrite
        wr(1'b0, 8'h00);
        chk("R5 same code no halt", core_run, 1);
        chk("R5 pll stays off", pll_en, 0);
        // R7 restart while running ignored
        wr(1'b1, 8'h18);
        chk("R7 restart while running", core_run, 1);

        // R4 change to x4 with enhanced off
        wr(1'b0, 8'h30);
        chk("R4 halted", core_run, 0);
        chk("R4 pll on", pll_en, 1);
        chk("R3 quad code", mult_sel, 3);
        idle(1);
        chk("R10 err set", cfg_err, 1);
        // R7 wrong command ignored
        wr(1'b1, 8'h17);
        idle(1);
        chk("R7 wrong command", core_run, 0);
        // R8 pending restart
        wr(1'b1, 8'h18);
        idle(4);
        chk("R8 still halted without lock", core_run, 0);
        pll_lock = 1'b1;
        @(negedge clk);
        chk("R8 run after lock", core_run, 1);
        // R6 second change ignored
        wr(1'b0, 8'h18);
        chk("R6 second change ignored", mult_sel, 3);
        chk("R6 no second halt", core_run, 1);
        idle(2);
        chk("R10 err sticky", cfg_err, 1);
        chk("R11 enhanced on", enh_func_en, 1);

        // fresh reset: change with lock already high
        do_reset();
        chk("R1 err cleared", cfg_err, 0);
        wr(1'b0, 8'h18);
        chk("R4 double code", mult_sel, 1);
        chk("R4 halted again", core_run, 0);
        wr(1'b1, 8'h12);
        chk("R7 other byte", core_run, 0);
        wr(1'b1, 8'h18);
        chk("R7 immediate restart", core_run, 1);
        idle(3);
        chk("R10 no err at x2", cfg_err, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule